// File: doc/BRIEF.md
# Power Sequencer Control and Status Register Block

This block holds the register state and control logic of an eight-channel power controller. It sits behind a plain register bus with an 8-bit sub-address and 8-bit data, such as the one a serial slave decodes. It holds one global control register and drives the per-channel enable outputs. It also shows power-good, undervoltage and temperature information in three read-only status registers.

The control register has two self-clearing bits. A power-cycle bit holds every channel enable low for a timed interval and then clears itself. A sample-request bit raises a request towards an external temperature converter and clears itself when the converter reports completion. The block keeps the returned 7-bit code and compares it with a programmable warning threshold. An override bit blocks the enable pins, so that channels can be switched off through register writes even when the pins are tied high.

Top module: `pwrseq_regs`

## Requirements
- R1: After a synchronous active-low reset, the control register (sub-address 0Bh) reads 00h, the temperature register (0Eh) reads 00h, and the converter request output is low.
- R2: Writing 0Bh stores bits 6:2. They read back in place, bit 3 drives the shutdown pull-down output and bit 2 drives the slow-slew output. Bit 0 always reads 0, whatever was written.
- R3: While control bit 4 is 0, each channel enable output follows its enable pin. While bit 4 is 1, every channel enable output is 0 whatever the pins are.
- R4: Writing 1 to control bit 7 holds every channel enable output low for exactly HOLD_CYCLES clock cycles. Bit 7 reads 1 for that interval and then 0, and the enables return to their normal source.
- R5: Writing 1 to bit 7 again while the interval runs does not extend or restart it.
- R6: Writing 1 to control bit 1 raises the converter request, and bit 1 reads 1. When the converter done input is sampled high, bit 1 and the request clear and the code is stored in 0Eh bits 6:0. A done pulse while no request is pending changes nothing.
- R7: Writing 1 to bit 1 while a conversion is pending does not restart it: the request stays high, and a single done pulse completes it.
- R8: Sub-address 0Ch reads the power-good inputs and 0Dh reads the undervoltage inputs, with channel n in bit n-1.
- R9: 0Eh bit 7 is the warning flag. It is 1 when control bits 6:5 are non-zero and the stored code is at or above the threshold they select: 01 selects THR_LO, 10 selects THR_MID and 11 selects THR_HI. It is 0 when bits 6:5 are 00.
- R10: Writes to 0Ch, 0Dh, 0Eh and to undefined sub-addresses change nothing. Reads of undefined sub-addresses return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Sub-address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| en_pin | input | 8 | External channel enable pins |
| pgood_in | input | 8 | Per-channel power-good status |
| uv_in | input | 8 | Per-channel undervoltage status |
| adc_done | input | 1 | Converter completion pulse |
| adc_code | input | 7 | Converter result, valid with adc_done |
| adc_req | output | 1 | Converter sample request |
| ch_en | output | 8 | Per-channel enable outputs |
| pd_sel | output | 1 | Global shutdown pull-down select |
| slow_slew | output | 1 | Global slow-slew select |

## Verification
The hardest situations to reach are the collisions between a self-clearing bit and a fresh write. These are a second power-cycle write that lands in the middle of the hold interval, and a second sample request made while the first conversion is still pending. The stimulus sets a short hold length and issues the second write at a known cycle inside the interval. It then counts the cycles until bit 7 drops, so that any extension of the interval shows up as a wrong count. The converter is driven by hand from the bench, which lets done pulses arrive both with and without a pending request.

// File: rtl/pwrseq_pkg.sv
// Package: shared sub-addresses, widths and control field layout for the
// power sequencer register block. Assumes an 8-bit register bus.
package pwrseq_pkg;
    localparam int DW       = 8;
    localparam int CH_COUNT = 8;
    localparam int TW       = 7;

    localparam logic [7:0] ADDR_CTRL  = 8'h0B;
    localparam logic [7:0] ADDR_PGOOD = 8'h0C;
    localparam logic [7:0] ADDR_UV    = 8'h0D;
    localparam logic [7:0] ADDR_TEMP  = 8'h0E;

    // Stored control fields (bit 7 lives in the hold timer, bit 0 is unused)
    typedef struct packed {
        logic [1:0] thr_sel;     // bits 6:5
        logic       ignore_pins; // bit 4
        logic       pd_sel;      // bit 3
        logic       slow_slew;   // bit 2
        logic       temp_req;    // bit 1
    } ctrl_fields_t;
endpackage

// File: rtl/pwrseq_hold_timer.sv
// Module: power-cycle hold timer. A start pulse begins an interval of exactly
// HOLD_CYCLES clock cycles, during which active is high. Start is ignored
// while active. Assumes HOLD_CYCLES >= 1.
module pwrseq_hold_timer #(
    parameter int HOLD_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Count the hold interval and release at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                cnt    <= '0;
            end
        end else if (cnt == LAST) begin
            active <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwrseq_ctrl_reg.sv
// Module: global control register storage. Keeps bits 6:1, produces the
// start pulse for the hold timer and clears the sample request on converter
// completion. Assumes wr_ctrl is already qualified by the sub-address.
module pwrseq_ctrl_reg
    import pwrseq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctrl,
    input  logic [DW-1:0] wdata,
    input  logic         hold_active,
    input  logic         conv_done,
    output logic         hold_start,
    output ctrl_fields_t fields
);
    logic unused_bit0;
    assign unused_bit0 = wdata[0];

    // Power-cycle start: only when the timer is idle
    assign hold_start = wr_ctrl && wdata[7] && !hold_active;

    // Update stored fields; the request bit self-clears on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields <= '0;
        end else begin
            if (wr_ctrl) begin
                fields.thr_sel     <= wdata[6:5];
                fields.ignore_pins <= wdata[4];
                fields.pd_sel      <= wdata[3];
                fields.slow_slew   <= wdata[2];
            end
            if (fields.temp_req) begin
                if (conv_done) fields.temp_req <= 1'b0;
            end else if (wr_ctrl && wdata[1]) begin
                fields.temp_req <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwrseq_temp_mon.sv
// Module: temperature code capture and warning compare. Stores the code
// when capture is high; the warning is a compare of the stored code with the
// threshold selected by thr_sel (00 disables). Assumes THR_LO<=THR_MID<=THR_HI.
module pwrseq_temp_mon #(
    parameter int TW      = 7,
    parameter int THR_LO  = 40,
    parameter int THR_MID = 60,
    parameter int THR_HI  = 80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [TW-1:0] code_in,
    input  logic [1:0]    thr_sel,
    output logic [TW-1:0] code,
    output logic          warn
);
    logic [TW-1:0] limit;

    // Hold the most recent conversion result
    always_ff @(posedge clk) begin
        if (!rst_n)       code <= '0;
        else if (capture) code <= code_in;
    end

    // Map the threshold select to a code and compare
    always_comb begin
        unique case (thr_sel)
            2'b01:   limit = TW'(THR_LO);
            2'b10:   limit = TW'(THR_MID);
            2'b11:   limit = TW'(THR_HI);
            default: limit = '0;
        endcase
        warn = (thr_sel != 2'b00) && (code >= limit);
    end
endmodule

// File: rtl/pwrseq_regs.sv
// Module: top of the power sequencer register block. Decodes bus writes,
// muxes read data, and gates per-channel enables by the hold timer and the
// pin override. Assumes one write per bus_wr cycle and combinational reads.
module pwrseq_regs
    import pwrseq_pkg::*;
#(
    parameter int HOLD_CYCLES = 50_000_000,
    parameter int THR_LO      = 40,
    parameter int THR_MID     = 60,
    parameter int THR_HI      = 80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [7:0]          bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [CH_COUNT-1:0] en_pin,
    input  logic [CH_COUNT-1:0] pgood_in,
    input  logic [CH_COUNT-1:0] uv_in,
    input  logic                adc_done,
    input  logic [TW-1:0]       adc_code,
    output logic                adc_req,
    output logic [CH_COUNT-1:0] ch_en,
    output logic                pd_sel,
    output logic                slow_slew
);
    ctrl_fields_t  fields;
    logic          hold_active;
    logic          hold_start;
    logic          conv_done;
    logic [TW-1:0] temp_code;
    logic          warn;
    logic          wr_ctrl;

    assign wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
    assign conv_done = fields.temp_req && adc_done;

    pwrseq_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_ctrl),
        .wdata       (bus_wdata),
        .hold_active (hold_active),
        .conv_done   (adc_done),
        .hold_start  (hold_start),
        .fields      (fields)
    );

    pwrseq_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (hold_start),
        .active (hold_active)
    );

    pwrseq_temp_mon #(
        .TW(TW), .THR_LO(THR_LO), .THR_MID(THR_MID), .THR_HI(THR_HI)
    ) u_temp (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (conv_done),
        .code_in (adc_code),
        .thr_sel (fields.thr_sel),
        .code    (temp_code),
        .warn    (warn)
    );

    assign adc_req   = fields.temp_req;
    assign pd_sel    = fields.pd_sel;
    assign slow_slew = fields.slow_slew;

    // Per-channel enable gating: hold interval and override both force off
    for (genvar i = 0; i < CH_COUNT; i++) begin : g_chan
        assign ch_en[i] = en_pin[i] && !hold_active && !fields.ignore_pins;
    end

    // Read data multiplexer; undefined sub-addresses read zero
    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL:  bus_rdata = {hold_active, fields, 1'b0};
            ADDR_PGOOD: bus_rdata = pgood_in;
            ADDR_UV:    bus_rdata = uv_in;
            ADDR_TEMP:  bus_rdata = {warn, temp_code};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwrseq_regs_chk.sv
// Module: assertion checker for pwrseq_regs, attached with bind. Observes the
// top-level ports and the internal timer, request and temperature state.
module pwrseq_regs_chk #(
    parameter int THR_LO = 40
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ch_en,
    input logic       hold_active,
    input logic       adc_req,
    input logic       adc_done,
    input logic [6:0] temp_code,
    input logic       warn,
    input logic       bus_wr,
    input logic [7:0] bus_addr
);
    // R4: while the hold interval runs no channel is enabled
    a_r4_hold_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> (ch_en == 8'h00));

    // R6: a pending request persists until completion
    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && !adc_done) |=> adc_req);

    // R6, R7: completion always clears the request, even with a new write
    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && adc_done) |=> !adc_req);

    // R6: the stored code only moves on a completed conversion
    a_r6_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_req && adc_done) |=> $stable(temp_code));

    // R9: a warning implies the code reached at least the lowest threshold
    a_r9_warn_needs_code: assert property (@(posedge clk) disable iff (!rst_n)
        warn |-> (temp_code >= 7'(THR_LO)));

    // R5, R10: status writes do not start a hold interval
    a_r10_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_active && bus_wr && bus_addr != 8'h0B) |=> !hold_active);
endmodule

bind pwrseq_regs pwrseq_regs_chk #(.THR_LO(THR_LO)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_en       (ch_en),
    .hold_active (hold_active),
    .adc_req     (adc_req),
    .adc_done    (adc_done),
    .temp_code   (temp_code),
    .warn        (warn),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr)
);

// File: tb/pwrseq_regs_tb.sv
// Directed bench for pwrseq_regs: one task per scenario, each self-checking.
module pwrseq_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] en_pin = 8'h00;
    logic [7:0] pgood_in = 8'h00;
    logic [7:0] uv_in = 8'h00;
    logic       adc_done = 1'b0;
    logic [6:0] adc_code = 7'h00;
    logic       adc_req;
    logic [7:0] ch_en;
    logic       pd_sel;
    logic       slow_slew;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrseq_regs #(.HOLD_CYCLES(HOLD), .THR_LO(40), .THR_MID(60), .THR_HI(80)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_pin(en_pin),
        .pgood_in(pgood_in), .uv_in(uv_in), .adc_done(adc_done),
        .adc_code(adc_code), .adc_req(adc_req), .ch_en(ch_en),
        .pd_sel(pd_sel), .slow_slew(slow_slew)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic done_pulse(input logic [6:0] code);
        adc_code = code; adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(8'h0B, d); chk(d, 8'h00, "R1 ctrl");
        rd(8'h0E, d); chk(d, 8'h00, "R1 temp");
        chk(adc_req, 0, "R1 req");
    endtask

    task automatic t_fields();
        logic [7:0] d;
        wr(8'h0B, 8'h6D);
        rd(8'h0B, d); chk(d, 8'h6C, "R2 readback bit0 zero");
        chk({pd_sel, slow_slew}, 2'b11, "R2 outputs");
        wr(8'h0B, 8'h00);
        chk({pd_sel, slow_slew}, 2'b00, "R2 outputs cleared");
    endtask

    task automatic t_override();
        en_pin = 8'h5A; #1;
        chk(ch_en, 8'h5A, "R3 follow pins");
        wr(8'h0B, 8'h10);
        chk(ch_en, 8'h00, "R3 ignore");
        en_pin = 8'hFF; #1;
        chk(ch_en, 8'h00, "R3 ignore all high");
        wr(8'h0B, 8'h00);
        chk(ch_en, 8'hFF, "R3 restored");
    endtask

    task automatic t_hold(input bit rewrite);
        logic [7:0] d;
        int n = 0;
        en_pin = 8'hFF;
        wr(8'h0B, 8'h80);
        chk(ch_en, 8'h00, "R4 forced off");
        rd(8'h0B, d);
        while (d[7] && n < 200) begin
            n++;
            if (rewrite && n == 5) wr(8'h0B, 8'h80);
            else @(negedge clk);
            rd(8'h0B, d);
        end
        chk(n, HOLD, rewrite ? "R5 interval not extended" : "R4 interval length");
        chk(ch_en, 8'hFF, "R4 released");
    endtask

    task automatic t_conv();
        logic [7:0] d;
        done_pulse(7'd9);
        rd(8'h0E, d); chk(d, 8'h00, "R6 stray done ignored");
        wr(8'h0B, 8'h22);
        chk(adc_req, 1, "R6 request raised");
        rd(8'h0B, d); chk(d, 8'h22, "R6 bit1 reads 1");
        wr(8'h0B, 8'h22);
        chk(adc_req, 1, "R7 still pending");
        done_pulse(7'd39);
        chk(adc_req, 0, "R7 single done completes");
        rd(8'h0B, d); chk(d, 8'h20, "R6 bit1 cleared");
        rd(8'h0E, d); chk(d, 8'h27, "R9 code 39 below LO");
        wr(8'h0B, 8'h22); done_pulse(7'd40);
        rd(8'h0E, d); chk(d, 8'hA8, "R9 code 40 at LO");
        wr(8'h0B, 8'h62); done_pulse(7'd79);
        rd(8'h0E, d); chk(d, 8'h4F, "R9 79 below HI");
        wr(8'h0B, 8'h40);
        rd(8'h0E, d); chk(d, 8'hCF, "R9 79 above MID");
        wr(8'h0B, 8'h00);
        rd(8'h0E, d); chk(d, 8'h4F, "R9 disabled");
    endtask

    task automatic t_status();
        logic [7:0] d;
        pgood_in = 8'hA5; uv_in = 8'h3C;
        rd(8'h0C, d); chk(d, 8'hA5, "R8 pgood");
        rd(8'h0D, d); chk(d, 8'h3C, "R8 uv");
        wr(8'h0B, 8'h08);
        wr(8'h0C, 8'hFF); rd(8'h0C, d); chk(d, 8'hA5, "R10 pgood write");
        wr(8'h0E, 8'hFF); rd(8'h0E, d); chk(d, 8'h4F, "R10 temp write");
        wr(8'h20, 8'hFF); rd(8'h0B, d); chk(d, 8'h08, "R10 undefined write");
        chk(ch_en, 8'hFF, "R10 no hold started");
        rd(8'h0F, d); chk(d, 8'h00, "R10 undefined read 0F");
        rd(8'h00, d); chk(d, 8'h00, "R10 undefined read 00");
    endtask

    task automatic t_rst_again();
        logic [7:0] d;
        wr(8'h0B, 8'h7E);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        rd(8'h0B, d); chk(d, 8'h00, "R1 ctrl after reset");
        rd(8'h0E, d); chk(d, 8'h00, "R1 temp after reset");
        chk(adc_req, 0, "R1 req after reset");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_override();
        t_hold(1'b0);
        t_hold(1'b1);
        t_conv();
        t_status();
        t_rst_again();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule